// File: doc/BRIEF.md
# Prioritized Four-Channel DMA Engine

This block moves data from memory to memory over a single bus master port. It has four independent channels. Each channel holds a programmed source address, target address, unit count and control word. A channel starts in one of two ways: at once when software enables it, or when a vertical-blank, horizontal-blank or special request strobe arrives. A channel that has started is pending until its block is done. The unit is a halfword or a word. One unit is carried by a read of the source followed by a write of the same data to the target.

Arbitration happens again after every unit, and the lowest-numbered pending channel always wins. A channel that becomes pending mid-block therefore steals the bus at the next unit boundary. The interrupted channel continues later from its own running addresses and count. Every access carries a sequential or non-sequential tag. The first unit of a block is non-sequential and is followed by two idle bus cycles. When a block finishes, the channel can pulse an interrupt flag. The last channel can also raise a cartridge interrupt.

Top module: `dma4_engine`

## Requirements
- R1: Software programs a channel by selecting it on `cfgChan` and a register on `cfgSel`: 0 source, 1 target, 2 length, 3 control. Writing control bit 15 (enable) from 0 to 1 copies the programmed source, target and length into the running registers. A length of 0 means 2^CNT_W units. If the start timing field is 0, the channel becomes pending at once.
- R2: Control bit 10 selects the unit size. When it is 1, units are words, `busWordSize` is 1 and the address step is 4. When it is 0, units are halfwords and the step is 2.
- R3: The source mode in control bits 8:7 steps the source address after each unit. Value 0 adds the step, value 1 subtracts it, and values 2 and 3 leave the address unchanged.
- R4: The target mode in control bits 6:5 steps the target address after each unit. Value 0 adds the step, 1 subtracts it and 2 leaves it unchanged. Value 3 adds the step within the block and then restores the programmed target when the block completes.
- R5: Each unit is a read at the running source address followed by a write of the read data to the running target address. During each access `busReq`, `busWrite` and `busAddr` stay steady until a cycle in which `busAck` is high.
- R6: The first unit of a block has `busSeq` at 0 on both of its accesses, and exactly two cycles with `busIdle` high follow its write. No bus request is made during those cycles. Later units of the block have `busSeq` at 1 and no idle cycles.
- R7: Channel 0 has the highest priority and channel 3 the lowest. Arbitration is repeated after every unit. A higher-priority channel that becomes pending preempts a running block at the next unit boundary. The preempted block later resumes with sequential accesses from where it stopped.
- R8: The start timing field in control bits 13:12 works as follows. Value 1 makes a vertical-blank strobe set pending. Value 2 makes a horizontal-blank strobe set pending. Value 3 makes the special strobe set pending, but only on channel 3. A strobe has no effect on a disabled channel or on a channel whose timing field does not match it.
- R9: When a block's count runs out, the channel stops being pending. If control bit 9 (repeat) is set, the count reloads from the programmed length, the channel stays enabled, and the next block starts with a first unit again. If repeat is clear, the enable bit is cleared and later strobes are ignored.
- R10: When a block completes and control bit 14 is set, `chanIrq` pulses for one cycle on that channel's bit. When channel 3 completes a block with control bit 11 set, `cartIrq` also pulses for one cycle. No interrupt pulses without a completed block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgChan | input | 2 | Channel selected for the write |
| cfgSel | input | 2 | Register select: 0 source, 1 target, 2 length, 3 control |
| cfgData | input | DATA_W | Register write data |
| vblankStb | input | 1 | Vertical-blank trigger strobe |
| hblankStb | input | 1 | Horizontal-blank trigger strobe |
| specialStb | input | 1 | Special request strobe (channel 3 only) |
| busReq | output | 1 | Bus access request |
| busWrite | output | 1 | 1 write, 0 read |
| busAddr | output | ADDR_W | Access address |
| busWordSize | output | 1 | 1 word unit, 0 halfword unit |
| busSeq | output | 1 | Sequential access tag |
| busIdle | output | 1 | Idle bus cycle after a first unit |
| busWdata | output | DATA_W | Write data |
| busRdata | input | DATA_W | Read data, valid with busAck |
| busAck | input | 1 | Access accepted this cycle |
| chanIrq | output | 4 | Per-channel block-complete pulse |
| cartIrq | output | 1 | Cartridge interrupt pulse from channel 3 |

## Verification
The hardest case to reach is preemption in the middle of a block. The higher-priority strobe must land while the lower channel's unit is still running, so that the next arbitration picks the newcomer. The stimulus waits until it sees the lower channel's first write accepted at the bus port, then fires the horizontal-blank strobe on the next cycle. This is timed inside that unit's idle window. The bench then expects the whole higher-priority block, followed by the sequential remainder of the interrupted block. Random acknowledge delays and randomly configured single-channel blocks cover the address modes and unit sizes in many combinations.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int NUM_CH = 4;
  localparam int CHAN_W = $clog2(NUM_CH);
  localparam int CTL_W  = 16;

  // control word field positions
  localparam int CB_TGT_LO  = 5;
  localparam int CB_SRC_LO  = 7;
  localparam int CB_REPEAT  = 9;
  localparam int CB_WORD    = 10;
  localparam int CB_REQ     = 11;
  localparam int CB_TIME_LO = 12;
  localparam int CB_IRQ     = 14;
  localparam int CB_EN      = 15;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_TGT = 2'd1;
  localparam logic [1:0] SEL_LEN = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  typedef enum logic [2:0] {ST_ARB, ST_READ, ST_WRITE, ST_GAP1, ST_GAP2} seqState_t;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;     // channel owning the bus
    logic              grab;     // read data accepted
    logic              unitDone; // unit finished, update running state
    logic              useTgt;   // address from target side
  } pathCmd_t;
endpackage

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pending,
  input  logic [NUM_CH-1:0] firstUnit,
  input  logic              busAck,
  output pathCmd_t          cmd,
  output logic              busReq,
  output logic              busWrite,
  output logic              busIdle,
  output logic              busSeq
);
  seqState_t         state;
  logic [CHAN_W-1:0] curChan;
  logic [CHAN_W-1:0] pick;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) pick = CHAN_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_ARB;
      curChan <= '0;
    end else begin
      case (state)
        ST_ARB: if (|pending) begin
          curChan <= pick;
          state   <= ST_READ;
        end
        ST_READ:  if (busAck) state <= ST_WRITE;
        ST_WRITE: if (busAck) state <= firstUnit[curChan] ? ST_GAP1 : ST_ARB;
        ST_GAP1:  state <= ST_GAP2;
        default:  state <= ST_ARB;
      endcase
    end
  end

  assign cmd.chan     = curChan;
  assign cmd.grab     = (state == ST_READ) && busAck;
  assign cmd.unitDone = ((state == ST_WRITE) && busAck && !firstUnit[curChan]) ||
                        (state == ST_GAP2);
  assign cmd.useTgt   = (state == ST_WRITE);

  assign busReq   = (state == ST_READ) || (state == ST_WRITE);
  assign busWrite = (state == ST_WRITE);
  assign busIdle  = (state == ST_GAP1) || (state == ST_GAP2);
  assign busSeq   = !firstUnit[curChan];
endmodule

// File: rtl/dma4_path.sv
module dma4_path
  import dma4_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CHAN_W-1:0] cfgChan,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              vblankStb,
  input  logic              hblankStb,
  input  logic              specialStb,
  input  pathCmd_t          cmd,
  input  logic [DATA_W-1:0] busRdata,
  output logic [NUM_CH-1:0] pending,
  output logic [NUM_CH-1:0] firstUnit,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWordSize,
  output logic [NUM_CH-1:0] chanIrq,
  output logic              cartIrq
);
  localparam int RUN_W = CNT_W + 1;

  logic [ADDR_W-1:0] progSrc [NUM_CH];
  logic [ADDR_W-1:0] progTgt [NUM_CH];
  logic [CNT_W-1:0]  progLen [NUM_CH];
  logic [CTL_W-1:0]  ctl     [NUM_CH];
  logic [ADDR_W-1:0] runSrc  [NUM_CH];
  logic [ADDR_W-1:0] runTgt  [NUM_CH];
  logic [RUN_W-1:0]  runCnt  [NUM_CH];
  logic [ADDR_W-1:0] stepVal [NUM_CH];
  logic [NUM_CH-1:0] pend, first, hit, active, last;
  logic [DATA_W-1:0] dataHold;

  function automatic logic [RUN_W-1:0] fullCount(input logic [CNT_W-1:0] len);
    return (len == '0) ? (RUN_W'(1) << CNT_W) : {1'b0, len};
  endfunction

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic [1:0] timing;
    assign timing     = ctl[g][CB_TIME_LO +: 2];
    assign stepVal[g] = ctl[g][CB_WORD] ? ADDR_W'(4) : ADDR_W'(2);
    assign hit[g]     = ctl[g][CB_EN] &&
                        ((timing == 2'd1 && vblankStb) ||
                         (timing == 2'd2 && hblankStb) ||
                         (timing == 2'd3 && specialStb && (g == NUM_CH - 1)));
    assign active[g]  = cmd.unitDone && (cmd.chan == CHAN_W'(g));
    assign last[g]    = active[g] && (runCnt[g] == RUN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) begin
        progSrc[i] <= '0; progTgt[i] <= '0; progLen[i] <= '0; ctl[i] <= '0;
        runSrc[i]  <= '0; runTgt[i]  <= '0; runCnt[i]  <= '0;
      end
      pend <= '0; first <= '0; dataHold <= '0; chanIrq <= '0; cartIrq <= 1'b0;
    end else begin
      chanIrq <= '0;
      cartIrq <= 1'b0;
      if (cmd.grab) dataHold <= busRdata;
      for (int i = 0; i < NUM_CH; i++) begin
        if (active[i]) begin
          first[i]  <= 1'b0;
          runCnt[i] <= runCnt[i] - RUN_W'(1);
          case (ctl[i][CB_SRC_LO +: 2])
            2'd0:    runSrc[i] <= runSrc[i] + stepVal[i];
            2'd1:    runSrc[i] <= runSrc[i] - stepVal[i];
            default: ;
          endcase
          case (ctl[i][CB_TGT_LO +: 2])
            2'd1:    runTgt[i] <= runTgt[i] - stepVal[i];
            2'd2:    ;
            default: runTgt[i] <= runTgt[i] + stepVal[i];
          endcase
          if (last[i]) begin
            pend[i] <= 1'b0;
            if (ctl[i][CB_TGT_LO +: 2] == 2'd3) runTgt[i] <= progTgt[i];
            if (ctl[i][CB_REPEAT]) begin
              runCnt[i] <= fullCount(progLen[i]);
              first[i]  <= 1'b1;
            end else begin
              ctl[i][CB_EN] <= 1'b0;
            end
            if (ctl[i][CB_IRQ]) chanIrq[i] <= 1'b1;
            if (i == NUM_CH - 1 && ctl[i][CB_REQ]) cartIrq <= 1'b1;
          end
        end
        if (hit[i] && !(last[i] && !ctl[i][CB_REPEAT])) pend[i] <= 1'b1;
        if (cfgWe && cfgChan == CHAN_W'(i)) begin
          case (cfgSel)
            SEL_SRC: progSrc[i] <= cfgData[ADDR_W-1:0];
            SEL_TGT: progTgt[i] <= cfgData[ADDR_W-1:0];
            SEL_LEN: progLen[i] <= cfgData[CNT_W-1:0];
            default: begin
              ctl[i] <= cfgData[CTL_W-1:0];
              if (!cfgData[CB_EN]) begin
                pend[i] <= 1'b0;
              end else if (!ctl[i][CB_EN]) begin
                runSrc[i] <= progSrc[i];
                runTgt[i] <= progTgt[i];
                runCnt[i] <= fullCount(progLen[i]);
                first[i]  <= 1'b1;
                pend[i]   <= (cfgData[CB_TIME_LO +: 2] == 2'd0);
              end
            end
          endcase
        end
      end
    end
  end

  assign pending     = pend;
  assign firstUnit   = first;
  assign busAddr     = cmd.useTgt ? runTgt[cmd.chan] : runSrc[cmd.chan];
  assign busWdata    = dataHold;
  assign busWordSize = ctl[cmd.chan][CB_WORD];
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CHAN_W-1:0] cfgChan,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              vblankStb,
  input  logic              hblankStb,
  input  logic              specialStb,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWordSize,
  output logic              busSeq,
  output logic              busIdle,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busAck,
  output logic [NUM_CH-1:0] chanIrq,
  output logic              cartIrq
);
  pathCmd_t          cmd;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] firstUnit;

  dma4_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pending(pending), .firstUnit(firstUnit),
    .busAck(busAck), .cmd(cmd), .busReq(busReq), .busWrite(busWrite),
    .busIdle(busIdle), .busSeq(busSeq)
  );

  dma4_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgChan(cfgChan), .cfgSel(cfgSel),
    .cfgData(cfgData), .vblankStb(vblankStb), .hblankStb(hblankStb),
    .specialStb(specialStb), .cmd(cmd), .busRdata(busRdata),
    .pending(pending), .firstUnit(firstUnit), .busAddr(busAddr),
    .busWdata(busWdata), .busWordSize(busWordSize), .chanIrq(chanIrq),
    .cartIrq(cartIrq)
  );
endmodule

// File: rtl/dma4_checks.sv
module dma4_checks
  import dma4_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWrite,
  input logic              busAck,
  input logic              busIdle,
  input logic              busSeq,
  input logic [ADDR_W-1:0] busAddr,
  input logic [NUM_CH-1:0] chanIrq,
  input logic              cartIrq
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && busWrite == $past(busWrite) && busAddr == $past(busAddr)); // R5
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> !busReq); // R6
  AST_IDLE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busIdle) |=> busIdle); // R6
  AST_IDLE_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busIdle) |-> $past(busWrite && busAck && !busSeq)); // R6
  AST_IRQ_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanIrq)); // R10
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    (chanIrq != '0) |-> $past(busIdle || (busWrite && busAck))); // R10
  AST_CART_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    cartIrq |-> $past(busIdle || (busWrite && busAck))); // R10
endmodule

bind dma4_engine dma4_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite), .busAck(busAck),
  .busIdle(busIdle), .busSeq(busSeq), .busAddr(busAddr), .chanIrq(chanIrq),
  .cartIrq(cartIrq)
);

// File: tb/dma4_engine_bench.sv
module dma4_engine_bench;
  import dma4_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;

  logic clk, rstN, cfgWe, vblankStb, hblankStb, specialStb, busAck;
  logic [1:0] cfgChan, cfgSel;
  logic [31:0] cfgData, busRdata, busAddr, busWdata;
  logic busReq, busWrite, busWordSize, busSeq, busIdle, cartIrq;
  logic [3:0] chanIrq;

  dma4_engine #(.CNT_W(CNT_W)) u_dma4_engine (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgChan(cfgChan), .cfgSel(cfgSel),
    .cfgData(cfgData), .vblankStb(vblankStb), .hblankStb(hblankStb),
    .specialStb(specialStb), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busWordSize(busWordSize), .busSeq(busSeq),
    .busIdle(busIdle), .busWdata(busWdata), .busRdata(busRdata),
    .busAck(busAck), .chanIrq(chanIrq), .cartIrq(cartIrq)
  );

  int compared = 0, mismatched = 0;
  int logN = 0, expN = 0;
  int logKind [0:1023], expKind [0:1023];
  logic [31:0] logAddr [0:1023], expAddr [0:1023];
  logic [31:0] logData [0:1023], expData [0:1023];
  logic logSeq [0:1023], expSeq [0:1023];
  logic logWord [0:1023], expWord [0:1023];
  int irqCnt [0:3];
  int cartCnt = 0;
  logic [31:0] mSrc [0:3], mTgt [0:3], mTgtProg [0:3];

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction

  function automatic logic [31:0] mkCtl(input int en, irq, timing, drq, word, rep, sm, tm);
    return 32'((en << 15) | (irq << 14) | (timing << 12) | (drq << 11) |
               (word << 10) | (rep << 9) | (sm << 7) | (tm << 5));
  endfunction

  task automatic pushLog(input int k, input logic [31:0] a, input logic s, input logic [31:0] d,
                         input logic w);
    if (logN < 1024) begin
      logKind[logN] = k; logAddr[logN] = a; logSeq[logN] = s; logData[logN] = d;
      logWord[logN] = w; logN++;
    end
  endtask

  // bus responder: random acknowledge delay, read data from an address pattern
  initial begin
    busAck = 1'b0; busRdata = '0;
    forever begin
      @(negedge clk);
      busAck = 1'b0;
      if (rstN && busReq && $urandom_range(0, 2) != 0) begin
        busAck = 1'b1;
        if (busWrite) pushLog(1, busAddr, busSeq, busWdata, busWordSize);
        else begin
          busRdata = pat(busAddr);
          pushLog(0, busAddr, busSeq, 32'h0, busWordSize);
        end
      end
      if (busIdle) pushLog(2, 32'h0, 1'b0, 32'h0, 1'b0);
      for (int i = 0; i < 4; i++) if (chanIrq[i]) irqCnt[i]++;
      if (cartIrq) cartCnt++;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic addExp(input int k, input logic [31:0] a, input logic s, input logic [31:0] d,
                        input logic w);
    expKind[expN] = k; expAddr[expN] = a; expSeq[expN] = s; expData[expN] = d;
    expWord[expN] = w; expN++;
  endtask

  // expected bus traffic of one unit and the address update that follows it
  task automatic expUnit(input int ch, input int sm, input int tm, input int word,
                         input bit first, input bit last);
    logic [31:0] stp;
    stp = word ? 32'd4 : 32'd2;
    addExp(0, mSrc[ch], !first, 32'h0, word[0]);
    addExp(1, mTgt[ch], !first, pat(mSrc[ch]), word[0]);
    if (first) begin
      addExp(2, 32'h0, 1'b0, 32'h0, 1'b0);
      addExp(2, 32'h0, 1'b0, 32'h0, 1'b0);
    end
    if (sm == 0) mSrc[ch] = mSrc[ch] + stp;
    else if (sm == 1) mSrc[ch] = mSrc[ch] - stp;
    if (tm == 1) mTgt[ch] = mTgt[ch] - stp;
    else if (tm != 2) mTgt[ch] = mTgt[ch] + stp;
    if (last && tm == 3) mTgt[ch] = mTgtProg[ch];
  endtask

  task automatic expBlock(input int ch, input int sm, input int tm, input int word, input int n);
    for (int u = 0; u < n; u++) expUnit(ch, sm, tm, word, u == 0, u == n - 1);
  endtask

  task automatic checkLog(input string req);
    int n;
    n = (logN > expN) ? logN : expN;
    check(req, "bus event count", 32'(logN), 32'(expN));
    for (int i = 0; i < n && i < 1024; i++) begin
      if (i >= logN || i >= expN) break;
      check(req, $sformatf("event %0d kind", i), 32'(logKind[i]), 32'(expKind[i]));
      if (expKind[i] != 2) begin
        check(req, $sformatf("event %0d addr", i), logAddr[i], expAddr[i]);
        check(req, $sformatf("event %0d seq", i), 32'(logSeq[i]), 32'(expSeq[i]));
        check(req, $sformatf("event %0d size", i), 32'(logWord[i]), 32'(expWord[i]));
      end
      if (expKind[i] == 1) check(req, $sformatf("event %0d data", i), logData[i], expData[i]);
    end
  endtask

  task automatic clearLog();
    @(negedge clk);
    logN = 0; expN = 0; cartCnt = 0;
    for (int i = 0; i < 4; i++) irqCnt[i] = 0;
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgChan = 2'(ch); cfgSel = 2'(sel); cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] t, input int len,
                      input logic [31:0] c);
    wr(ch, 0, s); wr(ch, 1, t); wr(ch, 2, 32'(len));
    mSrc[ch] = s; mTgt[ch] = t; mTgtProg[ch] = t;
    wr(ch, 3, c);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 1) vblankStb = 1'b1; else if (which == 2) hblankStb = 1'b1; else specialStb = 1'b1;
    @(negedge clk);
    vblankStb = 1'b0; hblankStb = 1'b0; specialStb = 1'b0;
  endtask

  task automatic waitQuiet();
    int q = 0;
    while (q < 8) begin
      @(posedge clk);
      if (!busReq && !busIdle) q++; else q = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; cfgWe = 1'b0; cfgChan = '0; cfgSel = '0; cfgData = '0;
    vblankStb = 1'b0; hblankStb = 1'b0; specialStb = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R5", "reset busReq", 32'(busReq), 0);
    check("R6", "reset busIdle", 32'(busIdle), 0);
    check("R10", "reset chanIrq", 32'(chanIrq), 0);
    check("R10", "reset cartIrq", 32'(cartIrq), 0);

    // R1 R2 R5 R6 R10: immediate word block, increment both sides, irq on
    clearLog();
    prog(1, 32'h0000_1000, 32'h0000_2000, 3, mkCtl(1, 1, 0, 0, 1, 0, 0, 0));
    waitQuiet();
    expBlock(1, 0, 0, 1, 3);
    checkLog("R1");
    check("R10", "ch1 irq count", 32'(irqCnt[1]), 1);

    // R2 R3 R4: halfword, source decrements, target fixed, irq off
    clearLog();
    prog(2, 32'h0000_3010, 32'h0000_4000, 2, mkCtl(1, 0, 0, 0, 0, 0, 1, 2));
    waitQuiet();
    expBlock(2, 1, 2, 0, 2);
    checkLog("R3");
    check("R10", "ch2 irq off", 32'(irqCnt[2]), 0);

    // R7: channel 0 preempts channel 1 mid-block
    clearLog();
    prog(0, 32'h0000_5000, 32'h0000_5800, 2, mkCtl(1, 1, 2, 0, 1, 0, 0, 0));
    prog(1, 32'h0000_6000, 32'h0000_6800, 4, mkCtl(1, 1, 1, 0, 1, 0, 0, 0));
    pulse(1);
    while (logN < 2) @(posedge clk);
    pulse(2);
    waitQuiet();
    expUnit(1, 0, 0, 1, 1, 0);
    expBlock(0, 0, 0, 1, 2);
    expUnit(1, 0, 0, 1, 0, 0);
    expUnit(1, 0, 0, 1, 0, 0);
    expUnit(1, 0, 0, 1, 0, 1);
    checkLog("R7");
    check("R7", "ch0 irq", 32'(irqCnt[0]), 1);
    check("R7", "ch1 irq", 32'(irqCnt[1]), 1);

    // R4 R9: repeat with target reload, two vertical-blank blocks
    clearLog();
    wr(0, 3, 32'h0);
    prog(0, 32'h0000_7000, 32'h0000_7800, 2, mkCtl(1, 1, 1, 0, 1, 1, 0, 3));
    pulse(1); waitQuiet();
    pulse(1); waitQuiet();
    expBlock(0, 0, 3, 1, 2);
    expBlock(0, 0, 3, 1, 2);
    checkLog("R9");
    check("R10", "repeat irq count", 32'(irqCnt[0]), 2);

    // R8 R9: one-shot ignores later strobes; disabled and mismatched channels ignore strobes
    clearLog();
    wr(0, 3, 32'h0);
    prog(0, 32'h0000_8000, 32'h0000_8800, 1, mkCtl(1, 1, 1, 0, 1, 0, 0, 0));
    prog(2, 32'h0000_9000, 32'h0000_9800, 1, mkCtl(0, 1, 1, 0, 1, 0, 0, 0));
    pulse(1); waitQuiet();
    pulse(1); waitQuiet();
    pulse(2); waitQuiet();
    expBlock(0, 0, 0, 1, 1);
    checkLog("R9");
    check("R8", "one-shot irq count", 32'(irqCnt[0]), 1);
    check("R8", "disabled ch2 irq", 32'(irqCnt[2]), 0);

    // R8 R10: special strobe only on channel 3, cartridge interrupt
    clearLog();
    prog(2, 32'h0000_A000, 32'h0000_A800, 1, mkCtl(1, 1, 3, 1, 1, 0, 0, 0));
    pulse(3); waitQuiet();
    check("R8", "special on ch2 traffic", 32'(logN), 0);
    wr(2, 3, 32'h0);
    prog(3, 32'h0000_B000, 32'h0000_B800, 1, mkCtl(1, 1, 3, 1, 0, 0, 0, 0));
    pulse(3); waitQuiet();
    expBlock(3, 0, 0, 0, 1);
    checkLog("R8");
    check("R10", "ch3 irq", 32'(irqCnt[3]), 1);
    check("R10", "cartIrq count", 32'(cartCnt), 1);

    // R1: length 0 means 2^CNT_W units
    clearLog();
    prog(1, 32'h0000_C000, 32'h0000_D000, 0, mkCtl(1, 1, 0, 0, 0, 0, 0, 0));
    waitQuiet();
    expBlock(1, 0, 0, 0, 1 << CNT_W);
    checkLog("R1");

    // R2 R3 R4 R5: random single-channel immediate blocks
    for (int it = 0; it < 8; it++) begin
      int ch, sm, tm, wd, len;
      ch = $urandom_range(0, 3); sm = $urandom_range(0, 3); tm = $urandom_range(0, 3);
      wd = $urandom_range(0, 1); len = $urandom_range(1, 5);
      clearLog();
      prog(ch, {16'h0001, 16'($urandom) & 16'hFFFC}, {16'h0002, 16'($urandom) & 16'hFFFC}, len,
           mkCtl(1, 1, 0, 0, wd, 0, sm, tm));
      waitQuiet();
      expBlock(ch, sm, tm, wd, len);
      checkLog("R4");
      check("R10", "random irq", 32'(irqCnt[ch]), 1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule